// File: doc/BRIEF.md
# Host Register Port with Command Queue

This block is the host-facing front end of a graphics controller. The host sees two word locations, selected by a single register-select input. With select low, a write sets an internal pointer register and a read returns a summary status word. With select high, the access reaches whichever internal register the pointer names: either the queue entry or the control word. Command words and their parameters travel from host to drawing engine through an eight-word write queue. Result words travel back through an eight-word read queue.

A command holding register takes the oldest queued word automatically whenever the engine is idle and not halted. While a command is held, the engine draws its parameters one at a time from the same queue. The status word carries ready and empty flags for the queues so the host can pace itself, by polling or by interrupt. In DMA command mode the block requests single-word transfers whenever the write queue runs dry. Each acknowledged transfer enters the queue no matter what the pointer holds. A done input ends that mode.

Top module: `gfx_host_port`

## Requirements
- R1: After reset the status word reads 0xFF23 and the control word reads 0x8000. Status bits: 0 write queue not full, 1 write queue empty, 2 read queue not empty, 3 read queue full, 4 overflow error, 5 loader idle, 6 DMA mode, 7 interrupt pending, 15:8 read as ones. Control bits: 15 halt, 14 error clear (write-only, reads 0), 8 DMA mode, 3:0 interrupt enables.
- R2: Every cycle with cs_n low is one access. ack is high in exactly the following cycle, rdata is valid in that cycle, and ack is low otherwise.
- R3: With rs low, a write loads the 8-bit pointer from wdata[7:0] and a read returns the status word. Neither changes any other state.
- R4: With rs high, pointer value 0x00 selects the queue entry and 0x02 selects the control word. Any other pointer value reads 0 and ignores writes.
- R5: Host writes to the queue entry are held in order, up to 8 words. Status bit 1 clears once one word is held, and bit 0 clears once 8 are held.
- R6: A write to the full write queue is dropped and sets status bit 4. Writing the control word with bit 14 set clears it.
- R7: Words pushed by the engine are returned in order by queue-entry reads, up to 8 words; a further push is dropped. A read from the empty read queue returns 0.
- R8: When halt is clear, the loader is idle and the write queue holds a word, cmd_valid rises on the next clock with cmd_word equal to the oldest word. It stays high and stable until a cmd_done clock, then falls. The next word loads one clock later.
- R9: While a command is held, prm_valid shows that a queued word is present in prm_word, and each prm_pop clock removes it.
- R10: irq is the OR of: write queue not full with enable bit 0, write queue empty with bit 1, read queue not empty with bit 2, and error with bit 3. Status bit 7 mirrors irq.
- R11: In DMA mode, dreq is high exactly while the write queue is empty. A dack clock pushes wdata into the write queue whatever the pointer holds.
- R12: A dma_done clock clears DMA mode (control bit 8), so dreq is low from the next cycle.
- R13: Reset empties both queues and drops any held command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Access strobe, one access per low cycle |
| rs | input | 1 | Register select: 0 pointer/status, 1 selected register |
| rw_n | input | 1 | 1 read, 0 write |
| wdata | input | 16 | Host and DMA write data |
| rdata | output | 16 | Read data, valid while ack is high |
| ack | output | 1 | Transfer acknowledge |
| irq | output | 1 | Interrupt request |
| dreq | output | 1 | DMA request |
| dack | input | 1 | DMA acknowledge, pushes wdata |
| dma_done | input | 1 | Ends DMA command mode |
| cmd_word | output | 16 | Held command |
| cmd_valid | output | 1 | A command is held |
| cmd_done | input | 1 | Engine has finished the held command |
| prm_word | output | 16 | Next parameter word |
| prm_valid | output | 1 | prm_word is present |
| prm_pop | input | 1 | Consume prm_word |
| rsp_word | input | 16 | Result word from engine |
| rsp_push | input | 1 | Push rsp_word into the read queue |

## Verification
Read data and ack are due one clock after the access cycle. Status, irq and dreq follow state within the clock that changes that state. A command loads one clock after the queue, halt and idle conditions all hold. A cmd_done adds one clock before it falls, and the refill comes one clock later. The bench drives every input on the falling edge and samples on the next falling edge. That sampling point lies after exactly one rising edge, so each check counts whole clocks from its stimulus. Expected status words come from a model of queue counts and flags kept in the bench.

// File: rtl/hp_pkg.sv
// Shared constants for the host register port: data width, selectable
// register numbers and bit positions of the status and control words.
package hp_pkg;
    localparam int W = 16;

    // register numbers reached through the pointer when rs is high
    localparam int REG_ENTRY = 0;
    localparam int REG_CTRL  = 2;

    // control word bits
    localparam int CT_HALT   = 15;
    localparam int CT_ERRCLR = 14;
    localparam int CT_DMA    = 8;
    localparam int IEN_W     = 4;

    // status word bits
    localparam int ST_WRDY  = 0;
    localparam int ST_WEMP  = 1;
    localparam int ST_RRDY  = 2;
    localparam int ST_RFULL = 3;
    localparam int ST_ERR   = 4;
    localparam int ST_IDLE  = 5;
    localparam int ST_DMA   = 6;
    localparam int ST_IRQ   = 7;

    typedef struct packed {
        logic             halt;
        logic             dma;
        logic [IEN_W-1:0] ien;
    } ctrl_t;
endpackage

// File: rtl/hp_fifo.sv
// Synchronous FIFO of DEPTH words of W bits.
// Assumes: pop on empty does nothing; push on full is dropped unless a pop
// happens in the same cycle; 'dropped' flags a push that was lost.
module hp_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         dropped
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Qualify requests against occupancy
    always_comb begin
        do_pop  = pop && (cnt != '0);
        do_push = push && ((cnt != CW'(DEPTH)) || do_pop);
        dropped = push && !do_push;
        empty   = (cnt == '0);
        full    = (cnt == CW'(DEPTH));
        dout    = mem[rp];
    end

    // Storage write, no reset needed on data
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    // Pointer and occupancy bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= next_ptr(wp);
            if (do_pop)  rp <= next_ptr(rp);
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R6: a push into a full queue without pop leaves it unchanged
    assert_full_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && $stable(dout)));
endmodule

// File: rtl/hp_cmd_loader.sv
// Command holding register. Takes the oldest write-queue word when idle and
// not halted, holds it until the engine reports completion, and lets the
// engine consume following words as parameters meanwhile.
// Assumes: cmd_done is only meaningful while a command is held.
module hp_cmd_loader #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         halt,
    input  logic         q_empty,
    input  logic [W-1:0] q_head,
    input  logic         cmd_done,
    input  logic         prm_pop,
    output logic         q_pop,
    output logic [W-1:0] cmd_word,
    output logic         cmd_busy
);
    logic load;

    // Decide between loading a command and passing a parameter
    always_comb begin
        load  = !cmd_busy && !halt && !q_empty;
        q_pop = load || (cmd_busy && prm_pop && !q_empty);
    end

    // Hold the command until the engine finishes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_busy <= 1'b0;
            cmd_word <= '0;
        end else if (load) begin
            cmd_busy <= 1'b1;
            cmd_word <= q_head;
        end else if (cmd_busy && cmd_done) begin
            cmd_busy <= 1'b0;
        end
    end

    assert_hold_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && !cmd_done) |=> (cmd_busy && $stable(cmd_word)));

    assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_busy && cmd_done) |=> !cmd_busy);
endmodule

// File: rtl/hp_bus_decode.sv
// Turns one host access cycle into single-register strobes.
// Assumes: each cycle with cs_n low is exactly one access.
module hp_bus_decode #(
    parameter int AR_W = 8
) (
    input  logic            cs_n,
    input  logic            rs,
    input  logic            rw_n,
    input  logic [AR_W-1:0] ptr,
    output logic            ptr_wr,
    output logic            st_rd,
    output logic            ent_wr,
    output logic            ent_rd,
    output logic            ctl_wr,
    output logic            ctl_rd
);
    logic sel_ent, sel_ctl, acc;

    // Strobe generation from select, direction and pointer
    always_comb begin
        acc     = !cs_n;
        sel_ent = (ptr == AR_W'(hp_pkg::REG_ENTRY));
        sel_ctl = (ptr == AR_W'(hp_pkg::REG_CTRL));
        ptr_wr  = acc && !rs && !rw_n;
        st_rd   = acc && !rs && rw_n;
        ent_wr  = acc && rs && !rw_n && sel_ent;
        ent_rd  = acc && rs && rw_n && sel_ent;
        ctl_wr  = acc && rs && !rw_n && sel_ctl;
        ctl_rd  = acc && rs && rw_n && sel_ctl;
    end
endmodule

// File: rtl/gfx_host_port.sv
// Host register port: pointer/status word pair, control word, write and
// read queues, automatic command loading and cycle-stealing DMA fill.
// Assumes: synchronous host strobes (one access per cs_n-low cycle),
// synchronous active-low reset.
module gfx_host_port #(
    parameter int FIFO_DEPTH = 8,
    parameter int AR_W       = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_n,
    input  logic                rs,
    input  logic                rw_n,
    input  logic [hp_pkg::W-1:0] wdata,
    output logic [hp_pkg::W-1:0] rdata,
    output logic                ack,
    output logic                irq,
    output logic                dreq,
    input  logic                dack,
    input  logic                dma_done,
    output logic [hp_pkg::W-1:0] cmd_word,
    output logic                cmd_valid,
    input  logic                cmd_done,
    output logic [hp_pkg::W-1:0] prm_word,
    output logic                prm_valid,
    input  logic                prm_pop,
    input  logic [hp_pkg::W-1:0] rsp_word,
    input  logic                rsp_push
);
    import hp_pkg::*;

    logic [AR_W-1:0] ptr;
    ctrl_t           ctl;
    logic            err;
    logic            ptr_wr, st_rd, ent_wr, ent_rd, ctl_wr, ctl_rd;
    logic            wq_push, wq_pop, wq_empty, wq_full, wq_drop;
    logic [W-1:0]    wq_head;
    logic            rq_pop, rq_empty, rq_full, rq_drop;
    logic [W-1:0]    rq_head;
    logic            busy, dma_push;
    logic [W-1:0]    status, ctl_view;

    hp_bus_decode #(.AR_W(AR_W)) u_dec (
        .cs_n(cs_n), .rs(rs), .rw_n(rw_n), .ptr(ptr),
        .ptr_wr(ptr_wr), .st_rd(st_rd), .ent_wr(ent_wr), .ent_rd(ent_rd),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd)
    );

    // Queue push sources: host entry writes and DMA acknowledges
    always_comb begin
        dma_push = dack && ctl.dma;
        wq_push  = ent_wr || dma_push;
        rq_pop   = ent_rd && !rq_empty;
    end

    hp_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_wq (
        .clk(clk), .rst_n(rst_n), .push(wq_push), .din(wdata), .pop(wq_pop),
        .dout(wq_head), .empty(wq_empty), .full(wq_full), .dropped(wq_drop)
    );

    hp_fifo #(.W(W), .DEPTH(FIFO_DEPTH)) u_rq (
        .clk(clk), .rst_n(rst_n), .push(rsp_push), .din(rsp_word), .pop(rq_pop),
        .dout(rq_head), .empty(rq_empty), .full(rq_full), .dropped(rq_drop)
    );

    hp_cmd_loader #(.W(W)) u_ld (
        .clk(clk), .rst_n(rst_n), .halt(ctl.halt), .q_empty(wq_empty),
        .q_head(wq_head), .cmd_done(cmd_done), .prm_pop(prm_pop),
        .q_pop(wq_pop), .cmd_word(cmd_word), .cmd_busy(busy)
    );

    // Status, control view, interrupt and DMA request from current state
    always_comb begin
        irq = (ctl.ien[0] && !wq_full) || (ctl.ien[1] && wq_empty) ||
              (ctl.ien[2] && !rq_empty) || (ctl.ien[3] && err);
        status           = {8'hFF, 8'h00};
        status[ST_WRDY]  = !wq_full;
        status[ST_WEMP]  = wq_empty;
        status[ST_RRDY]  = !rq_empty;
        status[ST_RFULL] = rq_full;
        status[ST_ERR]   = err;
        status[ST_IDLE]  = !busy;
        status[ST_DMA]   = ctl.dma;
        status[ST_IRQ]   = irq;
        ctl_view         = '0;
        ctl_view[CT_HALT] = ctl.halt;
        ctl_view[CT_DMA]  = ctl.dma;
        ctl_view[IEN_W-1:0] = ctl.ien;
        dreq      = ctl.dma && wq_empty;
        cmd_valid = busy;
        prm_word  = wq_head;
        prm_valid = busy && !wq_empty;
    end

    // Pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (ptr_wr) ptr <= wdata[AR_W-1:0];
    end

    // Control word; dma_done wins over a simultaneous write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl.halt <= 1'b1;
            ctl.dma  <= 1'b0;
            ctl.ien  <= '0;
        end else begin
            if (ctl_wr) begin
                ctl.halt <= wdata[CT_HALT];
                ctl.dma  <= wdata[CT_DMA];
                ctl.ien  <= wdata[IEN_W-1:0];
            end
            if (dma_done) ctl.dma <= 1'b0;
        end
    end

    // Overflow error flag; a new overflow wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)                          err <= 1'b0;
        else if (wq_drop)                    err <= 1'b1;
        else if (ctl_wr && wdata[CT_ERRCLR]) err <= 1'b0;
    end

    // Acknowledge and read data, one clock after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack   <= 1'b0;
            rdata <= '0;
        end else begin
            ack <= !cs_n;
            if (st_rd)       rdata <= status;
            else if (ent_rd) rdata <= rq_empty ? '0 : rq_head;
            else if (ctl_rd) rdata <= ctl_view;
            else             rdata <= '0;
        end
    end

    assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> ack);

    assert_ack_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !ack);

    assert_dreq_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> wq_empty);

    assert_done_stops_R12: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> !dreq);

    assert_ptr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ptr_wr |=> $stable(ptr));
endmodule

// File: tb/gfx_host_port_test.sv
`timescale 1ns/1ps
module gfx_host_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rs = 1'b0, rw_n = 1'b1;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ack, irq, dreq;
    logic        dack = 1'b0, dma_done = 1'b0;
    logic [15:0] cmd_word;
    logic        cmd_valid;
    logic        cmd_done = 1'b0;
    logic [15:0] prm_word;
    logic        prm_valid;
    logic        prm_pop = 1'b0;
    logic [15:0] rsp_word = '0;
    logic        rsp_push = 1'b0;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    // bench model of block state
    int wc, rc;
    bit m_err, m_busy, m_dma;
    logic [3:0] m_en;

    always #2 clk = ~clk;

    gfx_host_port uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rs(rs), .rw_n(rw_n),
        .wdata(wdata), .rdata(rdata), .ack(ack), .irq(irq), .dreq(dreq),
        .dack(dack), .dma_done(dma_done), .cmd_word(cmd_word),
        .cmd_valid(cmd_valid), .cmd_done(cmd_done), .prm_word(prm_word),
        .prm_valid(prm_valid), .prm_pop(prm_pop), .rsp_word(rsp_word),
        .rsp_push(rsp_push)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic m_irq();
        return (m_en[0] && wc != 8) || (m_en[1] && wc == 0) ||
               (m_en[2] && rc != 0) || (m_en[3] && m_err);
    endfunction

    function automatic logic [15:0] exp_status();
        logic [15:0] s;
        s = 16'hFF00;
        s[0] = (wc != 8);
        s[1] = (wc == 0);
        s[2] = (rc != 0);
        s[3] = (rc == 8);
        s[4] = m_err;
        s[5] = !m_busy;
        s[6] = m_dma;
        s[7] = m_irq();
        return s;
    endfunction

    // one host access; result sampled one clock later, ack checked there
    task automatic access(input logic r, input logic rd, input logic [15:0] d,
                          output logic [15:0] q);
        @(negedge clk);
        cs_n = 1'b0; rs = r; rw_n = rd; wdata = d;
        @(negedge clk);
        cs_n = 1'b1; rw_n = 1'b1;
        q = rdata;
        chk("R2 ack", {15'd0, ack}, 16'd1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wc = 0; rc = 0; m_err = 0; m_busy = 0; m_dma = 0; m_en = '0;
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [15:0] q;
        do_reset();

        // R1 reset values
        access(0, 1, 16'h0, q);  chk("R1 status", q, 16'hFF23);
        chk("R13 no cmd after reset", {15'd0, cmd_valid}, 16'd0);
        access(0, 0, 16'h0002, q);
        access(1, 1, 16'h0, q);  chk("R1 ctrl", q, 16'h8000);
        @(negedge clk);
        chk("R2 ack idle", {15'd0, ack}, 16'd0);

        // R4 sweep over unmapped pointer values
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 2) continue;
            access(0, 0, 16'(a), q);
            access(1, 0, 16'hFFFF, q);
            access(1, 1, 16'h0, q);  chk("R4 unmapped read", q, 16'h0000);
            access(0, 1, 16'h0, q);  chk("R4 R3 no side effect", q, exp_status());
        end
        access(0, 0, 16'h0002, q);
        access(1, 1, 16'h0, q);  chk("R4 ctrl untouched", q, 16'h8000);

        // R5 R6 fill sweep of write queue
        access(0, 0, 16'h0000, q);
        for (int k = 1; k <= 9; k++) begin
            access(1, 0, 16'hA000 + 16'(k), q);
            if (wc < 8) wc++; else m_err = 1;
            access(0, 1, 16'h0, q);
            chk(k == 9 ? "R6 overflow status" : "R5 fill status", q, exp_status());
        end

        // R6 clear error through control bit 14
        access(0, 0, 16'h0002, q);
        access(1, 0, 16'hC000, q);  m_err = 0;
        access(0, 1, 16'h0, q);  chk("R6 error cleared", q, exp_status());

        // R8 automatic load once halt is released
        access(1, 0, 16'h0000, q);
        @(negedge clk);
        m_busy = 1; wc = 7;
        chk("R8 cmd_valid", {15'd0, cmd_valid}, 16'd1);
        chk("R8 cmd_word oldest", cmd_word, 16'hA001);
        access(0, 1, 16'h0, q);  chk("R8 status busy", q, exp_status());

        // R9 parameter consumption
        chk("R9 prm_valid", {15'd0, prm_valid}, 16'd1);
        chk("R9 prm_word", prm_word, 16'hA002);
        for (int p = 3; p <= 5; p++) begin
            pulse(prm_pop);
            wc--;
            chk("R9 prm_word next", prm_word, 16'hA000 + 16'(p));
        end
        chk("R8 cmd stable", cmd_word, 16'hA001);
        pulse(cmd_done);
        chk("R8 released", {15'd0, cmd_valid}, 16'd0);
        @(negedge clk);
        wc--;
        chk("R8 next load", {15'd0, cmd_valid}, 16'd1);
        chk("R8 next word", cmd_word, 16'hA005);
        access(1, 0, 16'h8000, q);
        pulse(cmd_done);
        m_busy = 0;
        repeat (2) @(negedge clk);
        chk("R8 halted stays idle", {15'd0, cmd_valid}, 16'd0);
        access(0, 1, 16'h0, q);  chk("R8 halted status", q, exp_status());

        // R7 read queue fill sweep
        for (int k = 0; k < 9; k++) begin
            @(negedge clk); rsp_word = 16'hB000 + 16'(k); rsp_push = 1'b1;
            @(negedge clk); rsp_push = 1'b0;
            if (rc < 8) rc++;
            access(0, 1, 16'h0, q);  chk("R7 read queue status", q, exp_status());
        end
        access(0, 0, 16'h0000, q);
        for (int k = 0; k < 8; k++) begin
            access(1, 1, 16'h0, q);  rc--;
            chk("R7 read order", q, 16'hB000 + 16'(k));
        end
        access(1, 1, 16'h0, q);  chk("R7 empty read", q, 16'h0000);

        // R10 enable sweep in two queue states
        access(0, 0, 16'h0002, q);
        for (int pass = 0; pass < 2; pass++) begin
            if (pass == 1) begin
                @(negedge clk); rsp_word = 16'hB0FF; rsp_push = 1'b1;
                @(negedge clk); rsp_push = 1'b0;
                rc = 1;
            end
            for (int e = 0; e < 16; e++) begin
                access(1, 0, 16'h8000 | 16'(e), q);
                m_en = 4'(e);
                chk("R10 irq", {15'd0, irq}, {15'd0, m_irq()});
            end
            access(0, 1, 16'h0, q);  chk("R10 status irq bit", q, exp_status());
        end

        // R13 reset flushes queues
        do_reset();
        access(0, 1, 16'h0, q);  chk("R13 status after reset", q, 16'hFF23);
        access(1, 1, 16'h0, q);  chk("R13 read queue flushed", q, 16'h0000);

        // R11 DMA fill regardless of pointer
        access(0, 0, 16'h0002, q);
        access(1, 0, 16'h8100, q);  m_dma = 1;
        chk("R11 dreq on empty", {15'd0, dreq}, 16'd1);
        access(0, 0, 16'h0033, q);
        @(negedge clk); dack = 1'b1; wdata = 16'hC001;
        @(negedge clk); dack = 1'b0;
        wc = 1;
        chk("R11 dreq off when filled", {15'd0, dreq}, 16'd0);
        access(0, 1, 16'h0, q);  chk("R11 status after dma", q, exp_status());
        access(0, 0, 16'h0002, q);
        access(1, 0, 16'h0100, q);
        @(negedge clk);
        wc = 0; m_busy = 1;
        chk("R11 dma word loaded", cmd_word, 16'hC001);
        chk("R11 dreq again", {15'd0, dreq}, 16'd1);

        // R12 done ends DMA mode
        pulse(dma_done);
        m_dma = 0;
        chk("R12 dreq low", {15'd0, dreq}, 16'd0);
        access(1, 1, 16'h0, q);  chk("R12 ctrl dma cleared", q, 16'h0000);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule